// File: doc/BRIEF.md
# Wrapping Character Line Buffer

This block keeps an eight-character line for a small text or segment display and sits on a simple processor bus as an eight-byte window. A bus access carries a byte count (1, 2, 4 or 8) and a starting byte offset anywhere in the window. The access touches consecutive buffer bytes starting at that offset, and it wraps from the last byte back to the first. Reads return the selected bytes packed from the least significant lane upward.

Every write request produces a refresh toward the display side. The refresh is a one-cycle pulse with the whole eight-byte line in parallel, plus a marker pulse that tells the display to return to column zero before it paints the line. A separate greeting state machine watches the display's ready input. The first time that input rises, the block emits one blank character. It never emits the greeting again.

The greeting machine has three states:
- `GR_WAIT`: waits for a rising ready input.
- `GR_EMIT`: a one-cycle pulse with the blank character.
- `GR_DONE`: terminal.

Its transitions are:
- `WAIT->EMIT` on a ready rise.
- `EMIT->DONE` unconditionally.
- `DONE->DONE` forever.
- `WAIT->WAIT` otherwise.

Top module: `char_line_buffer`

## Requirements
- R1: After reset the line holds all zero bytes, and `bus_ack`, `bus_rdata`, `line_valid`, `line_cr` and `greet_valid` are all zero.
- R2: Every request, whatever its size, is acknowledged by `bus_ack` high for exactly the one cycle after the request cycle.
- R3: Byte k of an access (k = 0 least significant) addresses buffer index (`bus_off` + k) mod 8, so an access can wrap from index 7 to index 0.
- R4: A read returns byte k in bits 8k+7:8k of `bus_rdata` in the acknowledge cycle, with every lane at or above the access size set to zero.
- R5: A write changes only the buffer bytes its size selects; all other bytes keep their values. `line_data` byte j (bits 8j+7:8j) is buffer index j.
- R6: Every write request, legal or not, raises `line_valid` and `line_cr` together for exactly the one cycle after the request, and `line_data` then shows the updated line.
- R7: A `bus_size` value other than 1, 2, 4 or 8 reads as zero and writes no byte, yet is still acknowledged.
- R8: The first rise of `disp_ready` after reset raises `greet_valid` for one cycle, in the cycle after the rise is sampled, with `greet_char` = 8'h20.
- R9: After the greeting has been emitted, `greet_valid` stays low for the rest of the run, whatever `disp_ready` does.
- R10: A read request, or an idle cycle, never raises `line_valid`, and it leaves `line_data` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_off | input | 3 | Starting byte offset in the window |
| bus_size | input | 4 | Access size as a byte count |
| bus_wdata | input | 64 | Write data, byte k in bits 8k+7:8k |
| bus_ack | output | 1 | Access completed |
| bus_rdata | output | 64 | Read data, valid with `bus_ack` |
| disp_ready | input | 1 | Display side is ready |
| greet_valid | output | 1 | One-time blank-character pulse |
| greet_char | output | 8 | Greeting character (space) |
| line_valid | output | 1 | Refresh pulse |
| line_cr | output | 1 | Return-to-column-zero marker pulse |
| line_data | output | 64 | Full line, buffer index j in bits 8j+7:8j |

## Verification
The assertions assume that `bus_size` and `bus_off` are meaningful only while `bus_req` is high. They also assume that a request lasts one cycle and is not held over several cycles as a single access. The stimulus keeps to this by raising `bus_req` for a single cycle per access and leaving an idle cycle between accesses. The random sizes deliberately include illegal byte counts, so that the size check is exercised alongside offsets that wrap. `disp_ready` is toggled freely, because the greeting logic accepts any level pattern on that input.

// File: rtl/cdb_pkg.sv
package cdb_pkg;

    typedef enum logic [1:0] {
        GR_WAIT = 2'd0,
        GR_EMIT = 2'd1,
        GR_DONE = 2'd2
    } greet_state_e;

    localparam logic [7:0] BLANK_CHAR = 8'h20;

endpackage

// File: rtl/cdb_lane_steer.sv
module cdb_lane_steer #(
    parameter int NBYTES = 8,
    parameter int BW     = 8,
    localparam int AW    = $clog2(NBYTES),
    localparam int SZW   = AW + 1,
    localparam int DW    = NBYTES * BW
) (
    input  logic [AW-1:0]     off,
    input  logic [SZW-1:0]    size,
    input  logic [DW-1:0]     wdata,
    input  logic [DW-1:0]     store,
    output logic              size_ok,
    output logic [NBYTES-1:0] byte_wen,
    output logic [DW-1:0]     wbytes,
    output logic [DW-1:0]     rdata
);

    logic [BW-1:0] st_b [NBYTES];
    logic [BW-1:0] wd_b [NBYTES];

    // legal sizes: nonzero power of two no larger than the window
    assign size_ok = (size != '0)
                  && ((size & (size - SZW'(1))) == '0)
                  && (size <= SZW'(NBYTES));

    for (genvar g = 0; g < NBYTES; g++) begin : g_unpack
        assign st_b[g] = store[g*BW +: BW];
        assign wd_b[g] = wdata[g*BW +: BW];
    end

    // read side: access lane k pulls buffer index (off + k) mod NBYTES
    for (genvar k = 0; k < NBYTES; k++) begin : g_rd
        logic [AW-1:0] idx;
        assign idx = off + AW'(k);
        assign rdata[k*BW +: BW] = (size_ok && (SZW'(k) < size)) ? st_b[idx] : '0;
    end

    // write side: buffer index j takes access lane (j - off) mod NBYTES
    for (genvar j = 0; j < NBYTES; j++) begin : g_wr
        logic [AW-1:0] rel;
        assign rel = AW'(j) - off;
        assign byte_wen[j]       = size_ok && (SZW'(rel) < size);
        assign wbytes[j*BW +: BW] = wd_b[rel];
    end

endmodule

// File: rtl/cdb_line_store.sv
module cdb_line_store #(
    parameter int NBYTES = 8,
    parameter int BW     = 8,
    localparam int DW    = NBYTES * BW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_fire,
    input  logic [NBYTES-1:0] byte_wen,
    input  logic [DW-1:0]     wbytes,
    output logic [DW-1:0]     line_data,
    output logic              line_valid,
    output logic              line_cr
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_data  <= '0;
            line_valid <= 1'b0;
            line_cr    <= 1'b0;
        end else begin
            line_valid <= wr_fire;
            line_cr    <= wr_fire;
            for (int j = 0; j < NBYTES; j++) begin
                if (wr_fire && byte_wen[j]) begin
                    line_data[j*BW +: BW] <= wbytes[j*BW +: BW];
                end
            end
        end
    end

    // R10: without a write the stored line never moves
    p_hold_without_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_fire |=> $stable(line_data));

    // R5: a write with no enabled byte leaves the line intact
    p_empty_mask_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_fire && byte_wen == '0) |=> $stable(line_data));

endmodule

// File: rtl/cdb_greet_fsm.sv
module cdb_greet_fsm
    import cdb_pkg::*;
#(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ready_in,
    output logic          greet_valid,
    output logic [BW-1:0] greet_char
);

    greet_state_e st, st_nxt;
    logic         ready_q;
    logic         ready_rise;

    assign ready_rise = ready_in && !ready_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= GR_WAIT;
            ready_q <= 1'b0;
        end else begin
            st      <= st_nxt;
            ready_q <= ready_in;
        end
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            GR_WAIT: if (ready_rise) st_nxt = GR_EMIT;
            GR_EMIT: st_nxt = GR_DONE;
            GR_DONE: st_nxt = GR_DONE;
            default: st_nxt = GR_WAIT;
        endcase
    end

    always_comb begin
        greet_valid = 1'b0;
        greet_char  = '0;
        unique case (st)
            GR_EMIT: begin
                greet_valid = 1'b1;
                greet_char  = BW'(BLANK_CHAR);
            end
            default: begin
                greet_valid = 1'b0;
                greet_char  = '0;
            end
        endcase
    end

    // R9: terminal state is never left
    p_done_sticks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st == GR_DONE) |=> (st == GR_DONE) && !greet_valid);

    // R8: the greeting lasts exactly one cycle
    p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        greet_valid |=> !greet_valid);

    // R8: a greeting is always preceded by a sampled rising ready
    p_greet_after_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(greet_valid) |-> $past(ready_in));

endmodule

// File: rtl/char_line_buffer.sv
module char_line_buffer #(
    parameter int NBYTES = 8,
    parameter int BW     = 8,
    localparam int AW    = $clog2(NBYTES),
    localparam int SZW   = AW + 1,
    localparam int DW    = NBYTES * BW
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_req,
    input  logic           bus_we,
    input  logic [AW-1:0]  bus_off,
    input  logic [SZW-1:0] bus_size,
    input  logic [DW-1:0]  bus_wdata,
    output logic           bus_ack,
    output logic [DW-1:0]  bus_rdata,
    input  logic           disp_ready,
    output logic           greet_valid,
    output logic [BW-1:0]  greet_char,
    output logic           line_valid,
    output logic           line_cr,
    output logic [DW-1:0]  line_data
);

    logic              size_ok;
    logic [NBYTES-1:0] byte_wen;
    logic [DW-1:0]     wbytes;
    logic [DW-1:0]     steer_rdata;
    logic              wr_fire;
    logic              rd_fire;

    assign wr_fire = bus_req && bus_we;
    assign rd_fire = bus_req && !bus_we;

    cdb_lane_steer #(.NBYTES(NBYTES), .BW(BW)) u_steer (
        .off      (bus_off),
        .size     (bus_size),
        .wdata    (bus_wdata),
        .store    (line_data),
        .size_ok  (size_ok),
        .byte_wen (byte_wen),
        .wbytes   (wbytes),
        .rdata    (steer_rdata)
    );

    cdb_line_store #(.NBYTES(NBYTES), .BW(BW)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_fire    (wr_fire),
        .byte_wen   (byte_wen),
        .wbytes     (wbytes),
        .line_data  (line_data),
        .line_valid (line_valid),
        .line_cr    (line_cr)
    );

    cdb_greet_fsm #(.BW(BW)) u_greet (
        .clk         (clk),
        .rst_n       (rst_n),
        .ready_in    (disp_ready),
        .greet_valid (greet_valid),
        .greet_char  (greet_char)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ack   <= bus_req;
            bus_rdata <= rd_fire ? steer_rdata : '0;
        end
    end

    // R2: one acknowledge per request, none otherwise
    p_ack_follows_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |=> bus_ack);
    p_no_spurious_ack_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |=> !bus_ack);

    // R6: every write request refreshes the display with its marker
    p_refresh_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we) |=> (line_valid && line_cr));

    // R10: no refresh without a write
    p_no_refresh_otherwise_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_req && bus_we) |=> !line_valid);

    // R4: single-byte reads leave all upper lanes zero
    p_narrow_read_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && bus_size == SZW'(1)) |=> (bus_rdata[DW-1:BW] == '0));

    // R7: illegal sizes neither change the line nor return data
    p_illegal_write_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && !size_ok) |=> $stable(line_data));
    p_illegal_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_we && !size_ok) |=> (bus_rdata == '0));

endmodule

// File: tb/char_line_buffer_tb.sv
module char_line_buffer_tb;

    localparam int NB  = 8;
    localparam int BW  = 8;
    localparam int AW  = 3;
    localparam int SZW = 4;
    localparam int DW  = NB * BW;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           bus_req = 1'b0;
    logic           bus_we = 1'b0;
    logic [AW-1:0]  bus_off = '0;
    logic [SZW-1:0] bus_size = '0;
    logic [DW-1:0]  bus_wdata = '0;
    logic           bus_ack;
    logic [DW-1:0]  bus_rdata;
    logic           disp_ready = 1'b0;
    logic           greet_valid;
    logic [BW-1:0]  greet_char;
    logic           line_valid;
    logic           line_cr;
    logic [DW-1:0]  line_data;

    char_line_buffer u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_req(bus_req), .bus_we(bus_we), .bus_off(bus_off),
        .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .disp_ready(disp_ready),
        .greet_valid(greet_valid), .greet_char(greet_char),
        .line_valid(line_valid), .line_cr(line_cr), .line_data(line_data)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    int greet_seen = 0;
    bit done = 1'b0;
    logic [7:0] mdl [NB];

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic bit legal(int sz);
        return (sz == 1) || (sz == 2) || (sz == 4) || (sz == 8);
    endfunction

    function automatic logic [DW-1:0] exp_read(int off, int sz);
        logic [DW-1:0] r = '0;
        if (legal(sz))
            for (int k = 0; k < sz; k++) r[k*8 +: 8] = mdl[(off + k) % NB];
        return r;
    endfunction

    function automatic logic [DW-1:0] model_line();
        logic [DW-1:0] r;
        for (int j = 0; j < NB; j++) r[j*8 +: 8] = mdl[j];
        return r;
    endfunction

    // greeting monitor (R8, R9)
    always @(negedge clk) begin
        if (rst_n && greet_valid) begin
            greet_seen++;
            check("R8 greet_char", DW'(greet_char), DW'(8'h20));
        end
    end

    task automatic access(bit we, int off, int sz, logic [DW-1:0] wd, string tag);
        @(negedge clk);
        bus_req   = 1'b1;
        bus_we    = we;
        bus_off   = AW'(off);
        bus_size  = SZW'(sz);
        bus_wdata = wd;
        @(negedge clk);
        bus_req = 1'b0;
        check({"R2 ack ", tag}, DW'(bus_ack), DW'(1));
        if (we) begin
            if (legal(sz))
                for (int k = 0; k < sz; k++) mdl[(off + k) % NB] = wd[k*8 +: 8];
            check({"R6 refresh ", tag}, DW'({line_valid, line_cr}), DW'(2'b11));
            check({"R5 line ", tag}, line_data, model_line());
        end else begin
            check({"R4 rdata ", tag}, bus_rdata, exp_read(off, sz));
            check({"R10 no refresh ", tag}, DW'(line_valid), DW'(0));
            check({"R10 line held ", tag}, line_data, model_line());
        end
    endtask

    initial begin
        #(200000 * 10);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        report();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int j = 0; j < NB; j++) mdl[j] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 line_data", line_data, '0);
        check("R1 outputs", DW'({bus_ack, line_valid, line_cr, greet_valid}), DW'(0));
        check("R1 rdata", bus_rdata, '0);
        access(1'b0, 0, 8, '0, "R1 full read");

        // R3 wrap: 4-byte write at offset 6 covers 6,7,0,1
        access(1'b1, 6, 4, 64'h0000_0000_4443_4241, "R3 wrap write");
        access(1'b0, 7, 2, '0, "R3 wrap read");
        access(1'b0, 0, 8, '0, "R3 full read");
        // R3 8-byte write at offset 3
        access(1'b1, 3, 8, 64'h6867_6665_6463_6261, "R3 wide wrap");
        // R4 single byte read, upper lanes zero
        access(1'b0, 5, 1, '0, "R4 byte read");
        // R5 narrow write leaves neighbours
        access(1'b1, 2, 1, 64'hFFFF_FFFF_FFFF_FF5A, "R5 byte write");
        access(1'b0, 0, 8, '0, "R5 readback");
        // R7 illegal sizes
        access(1'b1, 1, 3, 64'h1111_1111_1111_1111, "R7 bad write");
        access(1'b1, 0, 0, 64'h2222_2222_2222_2222, "R7 zero write");
        access(1'b0, 0, 8, '0, "R7 readback");
        access(1'b0, 4, 5, '0, "R7 bad read");

        // R8 greeting
        check("R8 no greet before ready", DW'(greet_seen), DW'(0));
        @(negedge clk);
        disp_ready = 1'b1;
        @(negedge clk);
        check("R8 greet pulse", DW'(greet_valid), DW'(1));
        @(negedge clk);
        check("R8 greet one cycle", DW'(greet_valid), DW'(0));
        disp_ready = 1'b0;
        repeat (2) @(negedge clk);
        disp_ready = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 greet once", DW'(greet_seen), DW'(1));

        // random mix
        for (int i = 0; i < 400; i++) begin
            int sel = int'($urandom_range(0, 9));
            int sz;
            int off = int'($urandom_range(0, 7));
            bit we = 1'($urandom_range(0, 1));
            logic [DW-1:0] wd = {$urandom(), $urandom()};
            if (sel < 2)      sz = 1;
            else if (sel < 4) sz = 2;
            else if (sel < 6) sz = 4;
            else if (sel < 8) sz = 8;
            else              sz = int'($urandom_range(0, 15));
            if ($urandom_range(0, 7) == 0) disp_ready = ~disp_ready;
            access(we, off, sz, wd, "R3 random");
        end
        repeat (3) @(negedge clk);
        check("R9 greet once at end", DW'(greet_seen), DW'(1));
        report();
    end

endmodule